// File: doc/BRIEF.md
# In-Lane Vector Element Permute Unit

This unit rearranges the 32-bit elements of a vector register up to 512 bits wide. The vector is split into 128-bit segments of four elements each. Every destination element takes one of the four elements of its own segment and never reaches into another segment. The choice of element comes from one of two places. In immediate mode, one 8-bit immediate is shared by every segment. In variable mode, the choice comes from the two lowest bits of the matching element of a second (control) vector.

Several optional steps act on the result:
- Broadcast copies element 0 of a memory operand to every element position before the permute.
- A per-element write mask either keeps the old destination value (merge) or clears the element (zero).
- Every element above the selected vector length is forced to zero.

Elements are handled as raw bit patterns. The unit also raises an illegal-encoding flag for a few forbidden field combinations. Each request is accepted with `in_valid`, and the result appears one clock later with `out_valid`.

Top module: `lane_permute`

## Requirements
- R1: A 2-bit selector value s picks bits [32*s+31:32*s] of the 128-bit segment that holds the destination element. No element ever receives data from a different segment.
- R2: In immediate mode (`use_var`=0), element position p (0..3) within every segment uses `imm[2p+1:2p]`, and the same immediate serves every segment.
- R3: In variable mode (`use_var`=1), the selector of element e is `ctrl_vec[32e+1:32e]`. Bits [31:2] of each control element have no effect.
- R4: `vlen_sel` values 0, 1 and 2 give 4, 8 and 16 active elements (128, 256 and 512 bits). Value 3 behaves as 2. All result bits above the active length are zero.
- R5: When `bcast_req` and `src_mem` are both 1, element 0 of the operand is copied to every position before the permute. The operand is `src_data` in immediate mode and `ctrl_vec` in variable mode. If either signal is 0, broadcast has no effect.
- R6: With `mask_en`=0, every active element is written. With `mask_en`=1, active element j is written when `mask[j]`=1. When `mask[j]`=0, the element keeps `old_dst` if `zero_mode`=0 and becomes zero if `zero_mode`=1.
- R7: Mask bits at or above the active element count have no effect on the result.
- R8: `illegal` is 1 when `wbit`=1, or when `use_var`=0 and `vvvv`≠4'b1111. In variable mode, `vvvv` is ignored.
- R9: `out_valid` equals `in_valid` one clock earlier, and `result` and `illegal` belong to that request. A synchronous active-high `rst` clears `out_valid`, `result` and `illegal`.
- R10: Element bit patterns, including floating-point NaN and infinity codes, are moved unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| use_var | input | 1 | 1 = variable control, 0 = immediate control |
| vlen_sel | input | 2 | Active length: 0=128, 1=256, 2/3=512 bits |
| bcast_req | input | 1 | Broadcast requested |
| src_mem | input | 1 | Broadcast operand comes from memory |
| mask_en | input | 1 | Write masking enabled |
| zero_mode | input | 1 | 1 = zero masked elements, 0 = merge |
| mask | input | 16 | Per-element write mask |
| imm | input | 8 | Shared immediate selector byte |
| vvvv | input | 4 | Extra register-specifier field |
| wbit | input | 1 | Operand-width bit |
| src_data | input | 512 | Data vector |
| ctrl_vec | input | 512 | Control vector (variable mode) |
| old_dst | input | 512 | Previous destination value |
| out_valid | output | 1 | Result valid |
| result | output | 512 | New destination value |
| illegal | output | 1 | Illegal-encoding flag |

## Verification
The hardest case to reach is one where broadcast, masking and a short vector length all act at once. Broadcast in variable mode moves the control vector, not the data, so a wrong choice of operand changes only the selectors and is easy to miss. The bench builds those combinations directly: one control element 0 with a distinct low-bit code, merge masks whose set bits lie only above the active length, and data elements that are all different. Any mixing of segments or operands then shows up as a wrong element value. A stream of random requests, sent back to back, adds further mixes, and a scoreboard queue matches them in order.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    LEN_128 = 2'd0,
    LEN_256 = 2'd1,
    LEN_512 = 2'd2,
    LEN_ALT = 2'd3
  } vlen_e;

  function automatic int seg_count(input logic [1:0] code, input int max_seg);
    int n;
    case (vlen_e'(code))
      LEN_128: n = 1;
      LEN_256: n = 2;
      default: n = 4;
    endcase
    if (n > max_seg) n = max_seg;
    return n;
  endfunction
endpackage

// File: rtl/perm_bcast.sv
module perm_bcast #(
  parameter int ELEM_W  = 32,
  parameter int N_ELEMS = 16
) (
  input  logic [ELEM_W*N_ELEMS-1:0] vec_i,
  input  logic                      en_i,
  output logic [ELEM_W*N_ELEMS-1:0] vec_o
);
  for (genvar e = 0; e < N_ELEMS; e++) begin : g_el
    assign vec_o[e*ELEM_W +: ELEM_W] = en_i ? vec_i[ELEM_W-1:0]
                                            : vec_i[e*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/perm_select.sv
module perm_select #(
  parameter int ELEM_W    = 32,
  parameter int N_ELEMS   = 16,
  parameter int SEG_ELEMS = 4
) (
  input  logic [ELEM_W*N_ELEMS-1:0]              data_i,
  input  logic [ELEM_W*N_ELEMS-1:0]              ctrl_i,
  input  logic                                   use_var_i,
  input  logic [SEG_ELEMS*$clog2(SEG_ELEMS)-1:0] imm_i,
  output logic [ELEM_W*N_ELEMS-1:0]              perm_o
);
  localparam int SEL_W = $clog2(SEG_ELEMS);
  localparam int SEG_W = ELEM_W * SEG_ELEMS;

  for (genvar e = 0; e < N_ELEMS; e++) begin : g_el
    localparam int SEG = e / SEG_ELEMS;
    localparam int POS = e % SEG_ELEMS;
    logic [SEL_W-1:0] sel;
    logic [SEG_W-1:0] seg;
    assign sel = use_var_i ? ctrl_i[e*ELEM_W +: SEL_W] : imm_i[POS*SEL_W +: SEL_W];
    assign seg = data_i[SEG*SEG_W +: SEG_W];
    assign perm_o[e*ELEM_W +: ELEM_W] = seg[sel*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/perm_mask.sv
module perm_mask #(
  parameter int ELEM_W  = 32,
  parameter int N_ELEMS = 16
) (
  input  logic [ELEM_W*N_ELEMS-1:0]    perm_i,
  input  logic [ELEM_W*N_ELEMS-1:0]    old_i,
  input  logic [N_ELEMS-1:0]           mask_i,
  input  logic                         mask_en_i,
  input  logic                         zero_mode_i,
  input  logic [$clog2(N_ELEMS+1)-1:0] act_cnt_i,
  output logic [ELEM_W*N_ELEMS-1:0]    vec_o
);
  localparam int CNT_W = $clog2(N_ELEMS+1);

  for (genvar e = 0; e < N_ELEMS; e++) begin : g_el
    logic active, write;
    assign active = CNT_W'(e) < act_cnt_i;
    assign write  = !mask_en_i || mask_i[e];
    always_comb begin
      if (!active)          vec_o[e*ELEM_W +: ELEM_W] = '0;
      else if (write)       vec_o[e*ELEM_W +: ELEM_W] = perm_i[e*ELEM_W +: ELEM_W];
      else if (zero_mode_i) vec_o[e*ELEM_W +: ELEM_W] = '0;
      else                  vec_o[e*ELEM_W +: ELEM_W] = old_i[e*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/lane_permute.sv
module lane_permute #(
  parameter int ELEM_W    = 32,
  parameter int N_ELEMS   = 16,
  parameter int SEG_ELEMS = 4,
  parameter int SPEC_W    = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic                                   use_var,
  input  logic [1:0]                             vlen_sel,
  input  logic                                   bcast_req,
  input  logic                                   src_mem,
  input  logic                                   mask_en,
  input  logic                                   zero_mode,
  input  logic [N_ELEMS-1:0]                     mask,
  input  logic [SEG_ELEMS*$clog2(SEG_ELEMS)-1:0] imm,
  input  logic [SPEC_W-1:0]                      vvvv,
  input  logic                                   wbit,
  input  logic [ELEM_W*N_ELEMS-1:0]              src_data,
  input  logic [ELEM_W*N_ELEMS-1:0]              ctrl_vec,
  input  logic [ELEM_W*N_ELEMS-1:0]              old_dst,
  output logic                                   out_valid,
  output logic [ELEM_W*N_ELEMS-1:0]              result,
  output logic                                   illegal
);
  import perm_pkg::*;

  localparam int VEC_W = ELEM_W * N_ELEMS;
  localparam int N_SEG = N_ELEMS / SEG_ELEMS;
  localparam int CNT_W = $clog2(N_ELEMS+1);

  logic             bc_ok, data_bc, ctrl_bc, illegal_c;
  logic [VEC_W-1:0] data_v, ctrl_v, perm_v, final_v;
  logic [CNT_W-1:0] act_cnt;

  assign bc_ok   = bcast_req && src_mem;
  assign data_bc = bc_ok && !use_var;
  assign ctrl_bc = bc_ok && use_var;

  always_comb begin
    act_cnt   = CNT_W'(seg_count(vlen_sel, N_SEG) * SEG_ELEMS);
    illegal_c = wbit || (!use_var && (vvvv != '1));
  end

  perm_bcast #(.ELEM_W(ELEM_W), .N_ELEMS(N_ELEMS)) u_bc_data (
    .vec_i(src_data), .en_i(data_bc), .vec_o(data_v));

  perm_bcast #(.ELEM_W(ELEM_W), .N_ELEMS(N_ELEMS)) u_bc_ctrl (
    .vec_i(ctrl_vec), .en_i(ctrl_bc), .vec_o(ctrl_v));

  perm_select #(.ELEM_W(ELEM_W), .N_ELEMS(N_ELEMS), .SEG_ELEMS(SEG_ELEMS)) u_sel (
    .data_i(data_v), .ctrl_i(ctrl_v), .use_var_i(use_var), .imm_i(imm), .perm_o(perm_v));

  perm_mask #(.ELEM_W(ELEM_W), .N_ELEMS(N_ELEMS)) u_mask (
    .perm_i(perm_v), .old_i(old_dst), .mask_i(mask), .mask_en_i(mask_en),
    .zero_mode_i(zero_mode), .act_cnt_i(act_cnt), .vec_o(final_v));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= final_v;
        illegal <= illegal_c;
      end
    end
  end
endmodule

// File: rtl/perm_chk.sv
module perm_chk #(
  parameter int ELEM_W    = 32,
  parameter int N_ELEMS   = 16,
  parameter int SEG_ELEMS = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         use_var,
  input logic [1:0]                   vlen_sel,
  input logic                         bcast_req,
  input logic                         src_mem,
  input logic                         mask_en,
  input logic                         zero_mode,
  input logic [N_ELEMS-1:0]           mask,
  input logic [7:0]                   imm,
  input logic                         wbit,
  input logic [ELEM_W*N_ELEMS-1:0]    src_data,
  input logic [ELEM_W*N_ELEMS-1:0]    old_dst,
  input logic                         out_valid,
  input logic [ELEM_W*N_ELEMS-1:0]    result,
  input logic                         illegal
);
  localparam int SEG_W = ELEM_W * SEG_ELEMS;

  // R9
  lat_on_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R9
  lat_off_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(vlen_sel == 2'd0) |-> (result >> SEG_W) == '0);
  // R6
  zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(mask_en && zero_mode && !mask[0]) |-> result[ELEM_W-1:0] == '0);
  // R6
  merge_lane_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(mask_en && !zero_mode && !mask[0])
      |-> result[ELEM_W-1:0] == $past(old_dst[ELEM_W-1:0]));
  // R8
  wbit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(wbit) |-> illegal);
  // R2
  imm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(!use_var && imm[1:0] == 2'd0 && !mask_en && !(bcast_req && src_mem))
      |-> result[ELEM_W-1:0] == $past(src_data[ELEM_W-1:0]));
endmodule

bind lane_permute perm_chk #(.ELEM_W(ELEM_W), .N_ELEMS(N_ELEMS), .SEG_ELEMS(SEG_ELEMS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .use_var(use_var), .vlen_sel(vlen_sel),
  .bcast_req(bcast_req), .src_mem(src_mem), .mask_en(mask_en), .zero_mode(zero_mode),
  .mask(mask), .imm(imm), .wbit(wbit), .src_data(src_data), .old_dst(old_dst),
  .out_valid(out_valid), .result(result), .illegal(illegal));

// File: tb/sim_lane_permute.sv
`timescale 1ns/1ps
module sim_lane_permute;
  typedef struct {
    logic         uv;
    logic [1:0]   vl;
    logic         bc;
    logic         mem;
    logic         men;
    logic         zm;
    logic [15:0]  msk;
    logic [7:0]   im;
    logic [3:0]   vv;
    logic         w;
    logic [511:0] src;
    logic [511:0] ctl;
    logic [511:0] old;
  } stim_t;

  logic clk = 0, rst = 1, in_valid = 0;
  logic use_var = 0, bcast_req = 0, src_mem = 0, mask_en = 0, zero_mode = 0, wbit = 0;
  logic [1:0] vlen_sel = 0;
  logic [15:0] mask = 0;
  logic [7:0] imm = 0;
  logic [3:0] vvvv = 4'hF;
  logic [511:0] src_data = 0, ctrl_vec = 0, old_dst = 0;
  logic out_valid, illegal;
  logic [511:0] result;

  int total = 0, bad = 0;
  bit done = 0;
  logic [511:0] q_res[$];
  logic         q_ill[$];
  string        q_tag[$];

  always #2.5 clk = ~clk;

  lane_permute u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_var(use_var), .vlen_sel(vlen_sel),
    .bcast_req(bcast_req), .src_mem(src_mem), .mask_en(mask_en), .zero_mode(zero_mode),
    .mask(mask), .imm(imm), .vvvv(vvvv), .wbit(wbit), .src_data(src_data),
    .ctrl_vec(ctrl_vec), .old_dst(old_dst), .out_valid(out_valid), .result(result),
    .illegal(illegal));

  function automatic logic [511:0] ref_res(stim_t s);
    logic [511:0] d, c, r;
    int n;
    d = s.src; c = s.ctl; r = '0;
    if (s.bc && s.mem) begin
      for (int e = 0; e < 16; e++) begin
        if (s.uv) c[e*32 +: 32] = s.ctl[31:0];
        else      d[e*32 +: 32] = s.src[31:0];
      end
    end
    n = (s.vl == 2'd0) ? 4 : (s.vl == 2'd1) ? 8 : 16;
    for (int e = 0; e < 16; e++) begin
      int sel;
      logic [31:0] v;
      sel = s.uv ? int'(c[e*32 +: 2]) : int'(s.im[(e%4)*2 +: 2]);
      v = d[((e/4)*4 + sel)*32 +: 32];
      if (e >= n) v = '0;
      else if (s.men && !s.msk[e]) v = s.zm ? 32'h0 : s.old[e*32 +: 32];
      r[e*32 +: 32] = v;
    end
    return r;
  endfunction

  function automatic stim_t base();
    stim_t s;
    s.uv = 0; s.vl = 2; s.bc = 0; s.mem = 0; s.men = 0; s.zm = 0; s.msk = 0;
    s.im = 8'hE4; s.vv = 4'hF; s.w = 0;
    for (int e = 0; e < 16; e++) begin
      s.src[e*32 +: 32] = 32'hA5000000 | 32'(e * 16 + 1);
      s.ctl[e*32 +: 32] = 32'h0;
      s.old[e*32 +: 32] = 32'h0DD00000 | 32'(e);
    end
    return s;
  endfunction

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input stim_t s, input string tag);
    @(negedge clk);
    in_valid = 1; use_var = s.uv; vlen_sel = s.vl; bcast_req = s.bc; src_mem = s.mem;
    mask_en = s.men; zero_mode = s.zm; mask = s.msk; imm = s.im; vvvv = s.vv; wbit = s.w;
    src_data = s.src; ctrl_vec = s.ctl; old_dst = s.old;
    q_res.push_back(ref_res(s));
    q_ill.push_back(s.w || (!s.uv && s.vv != 4'hF));
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_res.size() == 0) begin
        check("R9 unexpected out_valid", 512'd1, 512'd0);
      end else begin
        logic [511:0] er;
        logic ei;
        string t;
        er = q_res.pop_front(); ei = q_ill.pop_front(); t = q_tag.pop_front();
        check({t, " result"}, result, er);
        check({t, " illegal"}, {511'd0, illegal}, {511'd0, ei});
      end
    end
  end

  initial begin
    #(1ms);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {511'd0, out_valid}, 512'd0);
    check("R9 reset result", result, 512'd0);
    check("R9 reset illegal", {511'd0, illegal}, 512'd0);
    @(negedge clk); rst = 0;

    s = base(); send(s, "R2 identity imm");
    s = base(); s.im = 8'h1B; send(s, "R2 reversed imm");
    s = base(); s.im = 8'hFF; send(s, "R1 each segment own element 3");
    s = base(); s.im = 8'b10_00_11_01; send(s, "R2 mixed imm");
    idle();
    @(negedge clk);
    check("R9 idle out_valid low", {511'd0, out_valid}, 512'd0);

    s = base(); s.uv = 1;
    for (int e = 0; e < 16; e++) s.ctl[e*32 +: 32] = {30'h3FFFFFF0 ^ 30'(e), 2'(e + 1)};
    send(s, "R3 variable high bits ignored");
    s = base(); s.uv = 1; s.vv = 4'h0; send(s, "R8 vvvv ignored in variable mode");
    s = base(); s.vv = 4'hE; send(s, "R8 imm vvvv illegal");
    s = base(); s.uv = 1; s.w = 1; send(s, "R8 wbit illegal");

    for (int v = 0; v < 4; v++) begin
      s = base(); s.vl = 2'(v); s.im = 8'h4E; send(s, $sformatf("R4 length code %0d", v));
    end

    s = base(); s.bc = 1; s.mem = 1; s.im = 8'h1B; send(s, "R5 data broadcast");
    s = base(); s.bc = 1; s.mem = 0; s.im = 8'h1B; send(s, "R5 broadcast without memory");
    s = base(); s.uv = 1; s.bc = 1; s.mem = 1; s.ctl[31:0] = 32'hFFFF_FF02;
    for (int e = 1; e < 16; e++) s.ctl[e*32 +: 32] = 32'(e % 4 == 2 ? 1 : 3);
    send(s, "R5 control broadcast");

    s = base(); s.men = 1; s.msk = 16'hA5C3; s.im = 8'h1B; send(s, "R6 merge mask");
    s = base(); s.men = 1; s.zm = 1; s.msk = 16'h5A3C; s.im = 8'h1B; send(s, "R6 zero mask");
    s = base(); s.men = 0; s.zm = 1; s.msk = 16'h0000; s.im = 8'h1B; send(s, "R6 masking off");
    s = base(); s.vl = 0; s.men = 1; s.msk = 16'hFFF0; s.im = 8'h39; send(s, "R7 mask above length merge");
    s = base(); s.vl = 1; s.men = 1; s.zm = 1; s.msk = 16'h00FF; s.im = 8'h39; send(s, "R7 mask above length zero");

    s = base(); s.im = 8'h1B;
    s.src[31:0] = 32'h7FC00001; s.src[63:32] = 32'hFF800000; s.src[95:64] = 32'hFFFFFFFF;
    s.src[127:96] = 32'h80000000; send(s, "R10 NaN and infinity patterns");

    for (int k = 0; k < 40; k++) begin
      s = base();
      s.uv = 1'($urandom); s.vl = 2'($urandom); s.bc = 1'($urandom); s.mem = 1'($urandom);
      s.men = 1'($urandom); s.zm = 1'($urandom); s.msk = 16'($urandom); s.im = 8'($urandom);
      s.vv = 4'($urandom); s.w = (k % 7 == 0);
      for (int e = 0; e < 16; e++) begin
        s.src[e*32 +: 32] = $urandom; s.ctl[e*32 +: 32] = $urandom; s.old[e*32 +: 32] = $urandom;
      end
      send(s, "R1 R6 random mix");
      if (k % 9 == 4) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 512'(q_res.size()), 512'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule